// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block walks a per-channel linked list of frame descriptors for a display engine. When a frame begins, it visits each of its channels in ascending order. For every enabled channel it reads a four-word descriptor from memory through a simple word-read master port. The four words are, in order: the next descriptor pointer, the frame source address, a frame identifier and a command word. Each channel can also hold a one-shot branch request. A pending request sends exactly one fetch to an alternate descriptor address, then clears itself.

Two address windows, fixed by parameters, bound every memory reference. A descriptor pointer whose sixteen bytes do not fit wholly inside a window is never read. A frame source address that is zero or lies outside both windows produces a bus-error strobe for that channel. The frame logic downstream consumes each channel's source address, transfer length and palette flag, together with the branch, start-of-frame, end-of-frame and bus-error strobes. The block pulses `done` after the last channel.

Top module: `frame_desc_fetcher`

## Requirements
- R1: A `frame_start` pulse while idle starts a pass that visits channels 0 to NCH-1 in ascending order. Disabled channels cause no memory reads. A one-cycle `done` pulse follows the last channel. A `frame_start` that arrives while `busy` is high is ignored.
- R2: For an enabled channel, four word reads go out at pointer+0, +4, +8 and +12. `mem_req` and `mem_addr` are held until `mem_rvalid`. The words are latched as next pointer (low four bits forced to 0), source address, frame ID and command.
- R3: Branch register bit 0 is a request and bit 1 is interrupt-on-branch. When bit 0 is set, the fetch uses bits 31:4 of the branch register as the descriptor address and clears bit 0. If bit 1 is also set, that channel's `branch_evt` pulses.
- R4: Configuration map: the branch register of channel c is at 0x040+4c. Channel c's next pointer, source, ID and command are at 0x200+16c plus 0x0, 0x4, 0x8 and 0xC. Writes keep next-pointer bits under mask 0xFFFFFFF0 and branch bits under mask 0xFFFFFFF3. The source, ID and command offsets ignore writes.
- R5: Every channel's source address, including a disabled channel's, reads 0 once a pass starts, until a descriptor loads it.
- R6: A descriptor pointer whose bytes [p, p+16) do not lie inside one window triggers no read. That channel's source stays 0.
- R7: In the check step, a source of 0 or one outside both windows pulses `berr_evt` for the channel. That channel then raises no start-of-frame or end-of-frame strobe.
- R8: `xfer_len` shows command bits 20:2 and `pal_load` shows bit 26. For a valid source without bit 26, bit 22 pulses `sof_evt` and bit 21 then pulses `eof_evt` one cycle later. A descriptor with bit 26 set raises neither.
- R9: A read answered with `mem_err` pulses `berr_evt`, abandons the channel and updates none of its descriptor registers. Its source stays 0.
- R10: Each strobe lasts one cycle, and at most one channel raises a start, end or bus-error strobe in any cycle.
- R11: After reset, all registers read 0, `busy`, `mem_req` and `done` are low, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a descriptor pass |
| chan_en | input | NCH | Per-channel enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_err | input | 1 | Read response error, valid with mem_rvalid |
| mem_rdata | input | 32 | Read response data |
| src_addr | output | NCH*32 | Per-channel frame source address |
| xfer_len | output | NCH*19 | Per-channel transfer length field |
| pal_load | output | NCH | Per-channel palette-load flag |
| branch_evt | output | NCH | Branch-taken strobe |
| sof_evt | output | NCH | Start-of-frame strobe |
| eof_evt | output | NCH | End-of-frame strobe |
| berr_evt | output | NCH | Bus-error strobe |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished strobe |

## Verification
Several properties are checked on every cycle:
- the read handshake holds its request and address steady until a response arrives;
- every descriptor read falls inside a window;
- strobes never overlap across channels;
- `done` is a single pulse seen only when idle;
- a start while idle always makes the block busy.

Other behaviour needs the bench's scenarios, which compare what the block produces against descriptors the bench placed in memory. These behaviours are:
- the ascending visiting order;
- the one-shot nature of the branch and its effect on the stored next pointer;
- the choice among bus error, start and end strobes and palette handling for each command and source;
- the untouched registers after an error response;
- the window edges.

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher #(
  parameter int          NCH       = 7,
  parameter logic [31:0] WIN0_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN0_SIZE = 32'h0400_0000,
  parameter logic [31:0] WIN1_BASE = 32'h5C00_0000,
  parameter logic [31:0] WIN1_SIZE = 32'h0004_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [NCH-1:0]      chan_en,
  input  logic                cfg_we,
  input  logic [11:0]         cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                mem_req,
  output logic [31:0]         mem_addr,
  input  logic                mem_rvalid,
  input  logic                mem_err,
  input  logic [31:0]         mem_rdata,
  output logic [NCH*32-1:0]   src_addr,
  output logic [NCH*19-1:0]   xfer_len,
  output logic [NCH-1:0]      pal_load,
  output logic [NCH-1:0]      branch_evt,
  output logic [NCH-1:0]      sof_evt,
  output logic [NCH-1:0]      eof_evt,
  output logic [NCH-1:0]      berr_evt,
  output logic                busy,
  output logic                done
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [31:0] NXT_MASK = 32'hFFFF_FFF0;
  localparam logic [31:0] BR_MASK  = 32'hFFFF_FFF3;
  localparam int B_REQ = 0, B_INT = 1, C_EOF = 21, C_SOF = 22, C_PAL = 26;

  typedef enum logic [2:0] {
    S_IDLE, S_SELECT, S_READ0, S_READ1, S_READ2, S_READ3, S_CHECK, S_NEXT
  } st_t;

  st_t             st_q;
  logic [CHW-1:0]  ch_q;
  logic [31:0]     ptr_q, w0_q, w1_q, w2_q;
  logic            eof_pend_q;
  logic [31:0]     nxt_q [NCH];
  logic [31:0]     src_q [NCH];
  logic [31:0]     id_q  [NCH];
  logic [31:0]     cmd_q [NCH];
  logic [31:0]     br_q  [NCH];

  function automatic logic in_win(input logic [31:0] a, input logic [32:0] span);
    logic [32:0] e0, e1;
    e0 = {1'b0, WIN0_BASE} + {1'b0, WIN0_SIZE};
    e1 = {1'b0, WIN1_BASE} + {1'b0, WIN1_SIZE};
    return (a >= WIN0_BASE && {1'b0, a} + span <= e0) ||
           (a >= WIN1_BASE && {1'b0, a} + span <= e1);
  endfunction

  wire           in_chan = cfg_addr[11:9] == 3'b001 && 32'(cfg_addr[8:4]) < NCH;
  wire           in_br   = cfg_addr[11:5] == 7'd2 && 32'(cfg_addr[4:2]) < NCH;
  wire [CHW-1:0] cch     = cfg_addr[4 +: CHW];
  wire [CHW-1:0] bch     = cfg_addr[2 +: CHW];

  always_comb begin
    cfg_rdata = '0;
    if (in_chan) begin
      case (cfg_addr[3:2])
        2'd0:    cfg_rdata = nxt_q[cch];
        2'd1:    cfg_rdata = src_q[cch];
        2'd2:    cfg_rdata = id_q[cch];
        default: cfg_rdata = cmd_q[cch];
      endcase
    end else if (in_br) begin
      cfg_rdata = br_q[bch];
    end
  end

  logic [1:0] woff;
  always_comb begin
    case (st_q)
      S_READ1: woff = 2'd1;
      S_READ2: woff = 2'd2;
      S_READ3: woff = 2'd3;
      default: woff = 2'd0;
    endcase
  end

  assign mem_req  = st_q inside {S_READ0, S_READ1, S_READ2, S_READ3};
  assign mem_addr = ptr_q + {28'd0, woff, 2'b00};
  assign busy     = st_q != S_IDLE;

  wire        cur_br  = br_q[ch_q][B_REQ];
  wire [31:0] sel_ptr = cur_br ? {br_q[ch_q][31:4], 4'b0000} : nxt_q[ch_q];
  wire [31:0] cur_src = src_q[ch_q];
  wire [31:0] cur_cmd = cmd_q[ch_q];

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign src_addr[g*32 +: 32] = src_q[g];
    assign xfer_len[g*19 +: 19] = cmd_q[g][20:2];
    assign pal_load[g]          = cmd_q[g][C_PAL];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      ch_q       <= '0;
      ptr_q      <= '0;
      w0_q       <= '0;
      w1_q       <= '0;
      w2_q       <= '0;
      eof_pend_q <= 1'b0;
      branch_evt <= '0;
      sof_evt    <= '0;
      eof_evt    <= '0;
      berr_evt   <= '0;
      done       <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        nxt_q[i] <= '0;
        src_q[i] <= '0;
        id_q[i]  <= '0;
        cmd_q[i] <= '0;
        br_q[i]  <= '0;
      end
    end else begin
      branch_evt <= '0;
      sof_evt    <= '0;
      eof_evt    <= '0;
      berr_evt   <= '0;
      done       <= 1'b0;
      case (st_q)
        S_IDLE: if (frame_start) begin
          for (int i = 0; i < NCH; i++) src_q[i] <= '0;
          ch_q <= '0;
          st_q <= S_SELECT;
        end
        S_SELECT: begin
          eof_pend_q <= 1'b0;
          if (!chan_en[ch_q]) begin
            st_q <= S_NEXT;
          end else begin
            ptr_q <= sel_ptr;
            if (cur_br) begin
              br_q[ch_q][B_REQ] <= 1'b0;
              if (br_q[ch_q][B_INT]) branch_evt[ch_q] <= 1'b1;
            end
            st_q <= in_win(sel_ptr, 33'd16) ? S_READ0 : S_CHECK;
          end
        end
        S_READ0, S_READ1, S_READ2, S_READ3: if (mem_rvalid) begin
          if (mem_err) begin
            berr_evt[ch_q] <= 1'b1;
            st_q           <= S_NEXT;
          end else begin
            case (st_q)
              S_READ0: begin w0_q <= mem_rdata; st_q <= S_READ1; end
              S_READ1: begin w1_q <= mem_rdata; st_q <= S_READ2; end
              S_READ2: begin w2_q <= mem_rdata; st_q <= S_READ3; end
              default: begin
                nxt_q[ch_q] <= w0_q & NXT_MASK;
                src_q[ch_q] <= w1_q;
                id_q[ch_q]  <= w2_q;
                cmd_q[ch_q] <= mem_rdata;
                st_q        <= S_CHECK;
              end
            endcase
          end
        end
        S_CHECK: begin
          if (cur_src == 32'd0 || !in_win(cur_src, 33'd1)) begin
            berr_evt[ch_q] <= 1'b1;
          end else if (!cur_cmd[C_PAL]) begin
            if (cur_cmd[C_SOF]) sof_evt[ch_q] <= 1'b1;
            eof_pend_q <= cur_cmd[C_EOF];
          end
          st_q <= S_NEXT;
        end
        S_NEXT: begin
          if (eof_pend_q) eof_evt[ch_q] <= 1'b1;
          if (ch_q == CHW'(NCH - 1)) begin
            done <= 1'b1;
            st_q <= S_IDLE;
          end else begin
            ch_q <= ch_q + 1'b1;
            st_q <= S_SELECT;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (cfg_we && in_chan && cfg_addr[3:2] == 2'd0) nxt_q[cch] <= cfg_wdata & NXT_MASK;
      if (cfg_we && in_br) br_q[bch] <= cfg_wdata & BR_MASK;
    end
  end
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
  parameter int          NCH       = 7,
  parameter logic [31:0] WIN0_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN0_SIZE = 32'h0400_0000,
  parameter logic [31:0] WIN1_BASE = 32'h5C00_0000,
  parameter logic [31:0] WIN1_SIZE = 32'h0004_0000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_start,
  input logic           mem_req,
  input logic [31:0]    mem_addr,
  input logic           mem_rvalid,
  input logic [NCH-1:0] branch_evt,
  input logic [NCH-1:0] sof_evt,
  input logic [NCH-1:0] eof_evt,
  input logic [NCH-1:0] berr_evt,
  input logic           busy,
  input logic           done
);
  wire [32:0] a33   = {1'b0, mem_addr} + 33'd4;
  wire        w_ok  = (mem_addr >= WIN0_BASE && a33 <= {1'b0, WIN0_BASE} + {1'b0, WIN0_SIZE}) ||
                      (mem_addr >= WIN1_BASE && a33 <= {1'b0, WIN1_BASE} + {1'b0, WIN1_SIZE});

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  assert_read_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> w_ok);
  assert_evt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_evt, eof_evt, berr_evt}));
  assert_branch_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(branch_evt));
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !busy) |=> busy);
endmodule

bind frame_desc_fetcher fdf_checker #(
  .NCH(NCH), .WIN0_BASE(WIN0_BASE), .WIN0_SIZE(WIN0_SIZE),
  .WIN1_BASE(WIN1_BASE), .WIN1_SIZE(WIN1_SIZE)
) u_fdf_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .branch_evt(branch_evt),
  .sof_evt(sof_evt), .eof_evt(eof_evt), .berr_evt(berr_evt), .busy(busy), .done(done)
);

// File: tb/frame_desc_fetcher_bench.sv
module frame_desc_fetcher_bench;
  localparam int          NCH = 7;
  localparam logic [31:0] MB  = 32'hA000_0000;
  localparam logic [31:0] W0S = 32'h0400_0000;
  localparam logic [31:0] W1B = 32'h5C00_0000;
  localparam logic [31:0] W1S = 32'h0004_0000;

  logic clk = 0, rst_n = 0, frame_start = 0, cfg_we = 0;
  logic [NCH-1:0] chan_en = '0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic mem_req, mem_rvalid, mem_err, busy, done;
  logic [31:0] mem_addr, mem_rdata;
  logic [NCH*32-1:0] src_addr;
  logic [NCH*19-1:0] xfer_len;
  logic [NCH-1:0] pal_load, branch_evt, sof_evt, eof_evt, berr_evt;

  always #10 clk = ~clk;

  frame_desc_fetcher u_frame_desc_fetcher (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_en(chan_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .src_addr(src_addr), .xfer_len(xfer_len), .pal_load(pal_load),
    .branch_evt(branch_evt), .sof_evt(sof_evt), .eof_evt(eof_evt), .berr_evt(berr_evt),
    .busy(busy), .done(done));

  logic [31:0] mem [0:63];
  logic        err_en = 0;
  logic [31:0] err_addr = '0;
  int tot_rd = 0, tot_done = 0, tot_log = 0;
  int tot_sof[NCH], tot_eof[NCH], tot_berr[NCH], tot_br[NCH];
  int b_rd, b_done, b_log;
  int b_sof[NCH], b_eof[NCH], b_berr[NCH], b_br[NCH];
  int sof_log[0:31];
  int n_chk = 0, n_fail = 0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (a >= MB && a < MB + 32'd256) return mem[(a - MB) >> 2];
    return 32'hDEAD_0000;
  endfunction

  initial begin
    for (int i = 0; i < NCH; i++) begin
      tot_sof[i] = 0; tot_eof[i] = 0; tot_berr[i] = 0; tot_br[i] = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 0; mem_err <= 0; mem_rdata <= '0;
    end else if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1;
      mem_rdata  <= lookup(mem_addr);
      mem_err    <= err_en && mem_addr == err_addr;
      tot_rd     <= tot_rd + 1;
    end else begin
      mem_rvalid <= 0; mem_err <= 0;
    end
    if (rst_n) begin
      if (done) tot_done <= tot_done + 1;
      for (int i = 0; i < NCH; i++) begin
        if (sof_evt[i]) begin tot_sof[i] <= tot_sof[i] + 1; sof_log[tot_log] <= i; tot_log <= tot_log + 1; end
        if (eof_evt[i]) tot_eof[i] <= tot_eof[i] + 1;
        if (berr_evt[i]) tot_berr[i] <= tot_berr[i] + 1;
        if (branch_evt[i]) tot_br[i] <= tot_br[i] + 1;
      end
    end
  end

  task automatic snap();
    b_rd = tot_rd; b_done = tot_done; b_log = tot_log;
    for (int i = 0; i < NCH; i++) begin
      b_sof[i] = tot_sof[i]; b_eof[i] = tot_eof[i]; b_berr[i] = tot_berr[i]; b_br[i] = tot_br[i];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic put_desc(input int idx, input logic [31:0] n, s, id, c);
    mem[idx] = n; mem[idx+1] = s; mem[idx+2] = id; mem[idx+3] = c;
  endtask

  task automatic run_frame(input bit restart);
    snap();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    if (restart) begin
      repeat (5) @(negedge clk);
      frame_start = 1; @(negedge clk); frame_start = 0;
    end
    for (int k = 0; k < 2000 && tot_done == b_done; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] src_of(input int c);
    return src_addr[c*32 +: 32];
  endfunction

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] cmd;
    logic [31:0] exp_src;
    logic exp_berr, exp_sof, exp_eof, exp_pal;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{MB + 32'h1000, 32'h0060_0100, MB + 32'h1000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{MB + 32'h2000, 32'h0000_0040, MB + 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h0,         32'h0060_0000, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000_0000, 32'h0060_0000, 32'h1000_0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{W1B + 32'h100, 32'h0020_0008, W1B + 32'h100, 1'b0, 1'b0, 1'b1, 1'b0},
    '{MB + 32'h3000, 32'h0460_0000, MB + 32'h3000, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R11 mem_req", {31'd0, mem_req}, 0);
    chk("R11 src0", src_of(0), 0);
    rd(12'h200, r); chk("R11 next0", r, 0);
    rd(12'h040, r); chk("R11 branch0", r, 0);

    // R2 R7 R8 vector table on channel 0
    chan_en = 7'b000_0001;
    for (int v = 0; v < 6; v++) begin
      put_desc(0, MB, VEC[v].src, 32'h100 + v, VEC[v].cmd);
      wr(12'h200, MB);
      run_frame(0);
      chk($sformatf("R2 vec%0d src", v), src_of(0), VEC[v].exp_src);
      chk($sformatf("R2 vec%0d reads", v), tot_rd - b_rd, 4);
      chk($sformatf("R7 vec%0d berr", v), tot_berr[0] - b_berr[0], {31'd0, VEC[v].exp_berr});
      chk($sformatf("R8 vec%0d sof", v), tot_sof[0] - b_sof[0], {31'd0, VEC[v].exp_sof});
      chk($sformatf("R8 vec%0d eof", v), tot_eof[0] - b_eof[0], {31'd0, VEC[v].exp_eof});
      chk($sformatf("R8 vec%0d pal", v), {31'd0, pal_load[0]}, {31'd0, VEC[v].exp_pal});
      chk($sformatf("R8 vec%0d len", v), {13'd0, xfer_len[18:0]}, {13'd0, VEC[v].cmd[20:2]});
    end

    // R4 register map and masks
    rd(12'h208, r); chk("R4 id readback", r, 32'h105);
    rd(12'h20C, r); chk("R4 cmd readback", r, 32'h0460_0000);
    wr(12'h204, 32'h1234_5678);
    rd(12'h204, r); chk("R4 src write ignored", r, MB + 32'h3000);
    wr(12'h200, 32'hA000_0047);
    rd(12'h200, r); chk("R4 next mask", r, 32'hA000_0040);
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, r); chk("R4 branch mask", r, 32'hFFFF_FFF3);
    wr(12'h040, 32'h0);

    // R3 branch with interrupt-on-branch
    put_desc(0, MB, MB + 32'h3000, 32'h1, 32'h0);
    put_desc(16, MB + 32'h80, MB + 32'h5000, 32'h77, 32'h0);
    put_desc(32, MB, MB + 32'h6000, 32'h78, 32'h0);
    wr(12'h200, MB);
    wr(12'h040, MB + 32'h43);
    run_frame(0);
    chk("R3 branch_evt", tot_br[0] - b_br[0], 1);
    chk("R3 branch src", src_of(0), MB + 32'h5000);
    rd(12'h040, r); chk("R3 request cleared", r, MB + 32'h42);
    rd(12'h200, r); chk("R3 next from branch desc", r, MB + 32'h80);
    run_frame(0);
    chk("R3 one-shot src", src_of(0), MB + 32'h6000);
    chk("R3 one-shot no evt", tot_br[0] - b_br[0], 0);
    wr(12'h040, MB + 32'h41);
    run_frame(0);
    chk("R3 no-int src", src_of(0), MB + 32'h5000);
    chk("R3 no-int evt", tot_br[0] - b_br[0], 0);

    // R6 descriptor window edges
    wr(12'h200, 32'h1000_0000);
    run_frame(0);
    chk("R6 outside reads", tot_rd - b_rd, 0);
    chk("R6 outside src", src_of(0), 0);
    chk("R7 outside berr", tot_berr[0] - b_berr[0], 1);
    wr(12'h200, W1B + W1S);
    run_frame(0);
    chk("R6 at end reads", tot_rd - b_rd, 0);
    wr(12'h200, MB - 32'h10);
    run_frame(0);
    chk("R6 below base reads", tot_rd - b_rd, 0);
    wr(12'h200, W1B + W1S - 32'h10);
    run_frame(0);
    chk("R6 last fitting reads", tot_rd - b_rd, 4);

    // R5 disabled channel cleared, no reads
    put_desc(0, MB, MB + 32'h3000, 32'h1, 32'h0);
    wr(12'h200, MB);
    run_frame(0);
    chk("R5 setup src", src_of(0), MB + 32'h3000);
    chan_en = '0;
    run_frame(0);
    chk("R5 cleared src", src_of(0), 0);
    chk("R1 disabled reads", tot_rd - b_rd, 0);
    chk("R1 done once", tot_done - b_done, 1);

    // R9 error response on word 2
    chan_en = 7'b000_0001;
    put_desc(0, MB + 32'h40, MB + 32'h3000, 32'h9, 32'h0040_0000);
    err_en = 1; err_addr = MB + 32'h8;
    run_frame(0);
    err_en = 0;
    chk("R9 berr", tot_berr[0] - b_berr[0], 1);
    chk("R9 src", src_of(0), 0);
    chk("R9 sof", tot_sof[0] - b_sof[0], 0);
    chk("R9 reads", tot_rd - b_rd, 3);
    rd(12'h200, r); chk("R9 next unchanged", r, MB);

    // R1 ascending order, restart ignored
    chan_en = 7'b100_0101;
    put_desc(0, MB, MB + 32'h100, 32'h0, 32'h0040_0000);
    put_desc(48, MB, MB + 32'h200, 32'h2, 32'h0040_0000);
    put_desc(32, MB, MB + 32'h300, 32'h6, 32'h0040_0000);
    wr(12'h200, MB); wr(12'h220, MB + 32'hC0); wr(12'h260, MB + 32'h80);
    run_frame(1);
    repeat (20) @(negedge clk);
    chk("R1 reads", tot_rd - b_rd, 12);
    chk("R1 single done", tot_done - b_done, 1);
    chk("R1 idle after", {31'd0, busy}, 0);
    chk("R1 sof count", tot_log - b_log, 3);
    chk("R1 order first", sof_log[b_log], 0);
    chk("R1 order second", sof_log[b_log+1], 2);
    chk("R1 order third", sof_log[b_log+2], 6);
    chk("R1 ch6 src", src_of(6), MB + 32'h300);
    finish_run();
  end
endmodule